// File: doc/BRIEF.md
# MIL-STD-1553B Manchester Word Codec

This block turns 16-bit payloads into serial 1553B words for one bus channel and recovers words arriving from a transceiver. On the transmit side a one-cycle start pulse loads a payload with a flag that selects a command/status or a data word. The block then drives a Manchester II differential pair for twenty bit times. These are a three-bit-time sync, sixteen data bits sent most significant first, and an odd parity bit. The inhibit output is asserted whenever no word is being sent.

On the receive side the differential pair passes through a configurable input synchronizer. It is sampled at the centre of every half-bit. The receiver reports the sync kind together with the sixteen data bits on a single-cycle valid strobe. If the word is bad it instead issues a single-cycle error strobe with a 2-bit class code and discards the word. A type check can be enabled so that a word whose sync is the wrong kind is rejected.

The system clock rate is fixed when the block is configured and may be 12, 16, 20 or 24 MHz. All bit timing at 1 Mbit/s is derived from it, and one half-bit lasts CLK_MHZ/2 clock cycles.

Top module: `mil_word_codec`

## Requirements
- R1: A transmitted word lasts 40 half-bits of exactly CLK_MHZ/2 clock cycles each. A line level is "high" when tx_pos=1 and tx_neg=0, and "low" when tx_pos=0 and tx_neg=1. The first six half-bits are the sync: high,high,high,low,low,low for a command/status word (tx_is_data=0) and the inverse for a data word (tx_is_data=1).
- R2: After the sync come data bits 15 down to 0 and then the parity bit, each as two half-bits. A one is sent high then low and a zero low then high.
- R3: The parity bit makes the count of ones across the 16 data bits plus parity odd.
- R4: Outside a word tx_inhibit=1 and tx_pos=tx_neg=0. tx_busy is 1 for exactly 40*(CLK_MHZ/2) cycles, starting with the cycle after the clock edge that accepts tx_start.
- R5: A tx_start that arrives while tx_busy=1 is ignored. The word in progress is not altered, and no new word follows it.
- R6: A well-formed received word produces one rx_valid pulse. rx_data carries the 16 bits and rx_is_data is 1 for a data sync (low first) or 0 for a command/status sync (high first).
- R7: A data or parity bit whose two half-bits are equal, or not a valid differential level, gives an rx_err pulse with rx_err_code=01.
- R8: A parity failure on an otherwise good word gives rx_err with code 10.
- R9: A malformed sync gives rx_err with code 11. So does a sync type that differs from rx_exp_data while rx_chk_type=1. Code 11 takes precedence over 01, and 01 over 10.
- R10: On an error there is no rx_valid, and rx_data and rx_is_data keep the values of the last good word.
- R11: The receiver starts a word only after it has seen an idle line (tx-style both-equal levels) since the previous word ended. Each word therefore yields exactly one strobe.
- R12: The half-bit length follows the CLK_MHZ parameter. At CLK_MHZ=20 a word spans 400 cycles, and a word looped from transmit to receive is recovered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_MHZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Single-cycle request to send a word |
| tx_data | input | 16 | Payload to send |
| tx_is_data | input | 1 | 1 selects the data sync, 0 the command/status sync |
| tx_busy | output | 1 | A word is being sent |
| tx_pos | output | 1 | Positive side of the differential output |
| tx_neg | output | 1 | Negative side of the differential output |
| tx_inhibit | output | 1 | Transmitter inhibit, high when idle |
| rx_pos | input | 1 | Positive side of the received pair |
| rx_neg | input | 1 | Negative side of the received pair |
| rx_chk_type | input | 1 | Enables the sync kind check |
| rx_exp_data | input | 1 | Expected kind when checking: 1 data, 0 command/status |
| rx_valid | output | 1 | Pulse: a good word was received |
| rx_data | output | 16 | Last good received payload |
| rx_is_data | output | 1 | Sync kind of the last good word |
| rx_err | output | 1 | Pulse: a received word was rejected |
| rx_err_code | output | 2 | Error class: 01 Manchester, 10 parity, 11 sync |

## Verification
On the transmit side, a fault in the half-bit counter or the shift pattern shows within the first few half-bits. It appears as a line level that departs from the expected level on some cycle, because every cycle of the word is compared. On the receive side, a misplaced sample point or a wrong pair index gives a wrong payload, a spurious error class or a missing strobe. That result appears within 40 half-bits of the start of the word. A receiver that fails to return to its idle wait shows as a second strobe from the tail of the parity bit.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
   localparam int unsigned PAYLOAD_W = 16;
   localparam int unsigned SYNC_HALVES = 6;
   localparam int unsigned WORD_HALVES = SYNC_HALVES + 2 * (PAYLOAD_W + 1);

   typedef enum logic [1:0] {
      ERR_NONE   = 2'b00,
      ERR_MANCH  = 2'b01,
      ERR_PARITY = 2'b10,
      ERR_SYNC   = 2'b11
   } err_e;

   function automatic int unsigned half_cycles(input int unsigned mhz);
      return mhz / 2;
   endfunction

   // Half-bit levels of a word, first-sent level in the top bit.
   function automatic logic [WORD_HALVES-1:0] word_halves(input logic [PAYLOAD_W-1:0] d,
                                                          input logic is_data);
      logic [WORD_HALVES-1:0] h;
      logic par;
      h = '0;
      h[WORD_HALVES-1 -: SYNC_HALVES] = is_data ? 6'b000111 : 6'b111000;
      for (int i = 0; i < PAYLOAD_W; i++) begin
         h[2*i+3] = d[i];
         h[2*i+2] = ~d[i];
      end
      par  = ~^d;
      h[1] = par;
      h[0] = ~par;
      return h;
   endfunction
endpackage

// File: rtl/mwc_sync.sv
module mwc_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= din;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign dout = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mwc_tx.sv
module mwc_tx
   import mwc_pkg::*;
#(
   parameter int unsigned HALF = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [PAYLOAD_W-1:0] data,
   input  logic                 is_data,
   output logic                 busy,
   output logic                 line_pos,
   output logic                 line_neg,
   output logic                 inhibit
);
   localparam int unsigned CW = $clog2(HALF + 1);
   localparam int unsigned IW = $clog2(WORD_HALVES);
   localparam logic [IW-1:0] LAST_HALF = IW'(WORD_HALVES - 1);

   logic [WORD_HALVES-1:0] pat_q;
   logic [IW-1:0]          idx_q;
   logic [CW-1:0]          cnt_q;
   logic                   active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_q    <= '0;
         idx_q    <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (!active_q) begin
         if (start) begin
            pat_q    <= word_halves(data, is_data);
            idx_q    <= '0;
            cnt_q    <= CW'(HALF - 1);
            active_q <= 1'b1;
         end
      end else if (cnt_q == '0) begin
         cnt_q <= CW'(HALF - 1);
         pat_q <= pat_q << 1;
         if (idx_q == LAST_HALF) active_q <= 1'b0;
         else idx_q <= idx_q + 1'b1;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy     = active_q;
   assign line_pos = active_q & pat_q[WORD_HALVES-1];
   assign line_neg = active_q & ~pat_q[WORD_HALVES-1];
   assign inhibit  = ~active_q;

   // R1: a level holds for a whole half-bit
   p_hold_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && cnt_q != '0) |=> ($stable(line_pos) && $stable(line_neg)));
   // R2: never both sides high
   p_lines_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_pos && line_neg));
   // R4: a word ends only after its last half-bit
   p_full_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_q) |-> $past(idx_q) == LAST_HALF);
   // R5: a start while busy does not restart the half counter
   p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && start && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/mwc_rx.sv
module mwc_rx
   import mwc_pkg::*;
#(
   parameter int unsigned HALF = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lpos,
   input  logic                 lneg,
   input  logic                 chk_type,
   input  logic                 exp_data,
   output logic                 valid,
   output logic [PAYLOAD_W-1:0] data,
   output logic                 is_data,
   output logic                 err,
   output logic [1:0]           err_code
);
   localparam int unsigned CW = $clog2(HALF + 1);
   localparam int unsigned IW = $clog2(WORD_HALVES);
   localparam logic [IW-1:0] LAST_HALF = IW'(WORD_HALVES - 1);
   localparam logic [IW-1:0] SYNC_END  = IW'(SYNC_HALVES);
   localparam logic [IW-1:0] SYNC_MID  = IW'(SYNC_HALVES / 2);

   typedef enum logic [1:0] {S_QUIET, S_IDLE, S_RUN} rx_state_e;

   rx_state_e             st_q;
   logic [CW-1:0]         cnt_q;
   logic [IW-1:0]         idx_q;
   logic                  first_q, sync_bad_q, man_bad_q, prev_q, prev_ok_q;
   logic [PAYLOAD_W-1:0]  sh_q;
   err_e                  code_q;

   logic lv, s, smp, sync_exp, pair_bad, fin_man, fin_sync, fin_par_ok, fin_type;

   assign lv  = lpos ^ lneg;
   assign s   = lpos;
   assign smp = (st_q == S_RUN) && (cnt_q == CW'(1));

   always_comb begin
      sync_exp   = (idx_q < SYNC_MID) ? first_q : ~first_q;
      pair_bad   = !prev_ok_q || !lv || (s == prev_q);
      fin_man    = man_bad_q | pair_bad;
      fin_type   = ~first_q;
      fin_sync   = sync_bad_q | (chk_type && (fin_type != exp_data));
      fin_par_ok = ^{sh_q, prev_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_QUIET;
         cnt_q <= '0;
         idx_q <= '0;
         first_q <= 1'b0;
         sync_bad_q <= 1'b0;
         man_bad_q <= 1'b0;
         prev_q <= 1'b0;
         prev_ok_q <= 1'b0;
         sh_q <= '0;
         valid <= 1'b0;
         err <= 1'b0;
         code_q <= ERR_NONE;
         data <= '0;
         is_data <= 1'b0;
      end else begin
         valid <= 1'b0;
         err   <= 1'b0;
         case (st_q)
            S_QUIET: if (!lv) st_q <= S_IDLE;
            S_IDLE: if (lv) begin
               st_q       <= S_RUN;
               cnt_q      <= CW'(HALF / 2);
               idx_q      <= '0;
               sync_bad_q <= 1'b0;
               man_bad_q  <= 1'b0;
            end
            S_RUN: if (smp) begin
               cnt_q <= CW'(HALF);
               idx_q <= idx_q + 1'b1;
               if (idx_q == '0) begin
                  first_q <= s;
                  if (!lv) sync_bad_q <= 1'b1;
               end else if (idx_q < SYNC_END) begin
                  if (!lv || s != sync_exp) sync_bad_q <= 1'b1;
               end else if (!idx_q[0]) begin
                  prev_q    <= s;
                  prev_ok_q <= lv;
               end else if (idx_q != LAST_HALF) begin
                  sh_q      <= {sh_q[PAYLOAD_W-2:0], prev_q};
                  man_bad_q <= man_bad_q | pair_bad;
               end else begin
                  st_q <= S_QUIET;
                  if (fin_sync) begin
                     err <= 1'b1; code_q <= ERR_SYNC;
                  end else if (fin_man) begin
                     err <= 1'b1; code_q <= ERR_MANCH;
                  end else if (!fin_par_ok) begin
                     err <= 1'b1; code_q <= ERR_PARITY;
                  end else begin
                     valid   <= 1'b1;
                     code_q  <= ERR_NONE;
                     data    <= sh_q;
                     is_data <= fin_type;
                  end
               end
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= S_QUIET;
         endcase
      end
   end

   assign err_code = code_q;

   // R6: valid is a single-cycle strobe
   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   // R9: an error strobe always carries a class
   p_err_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> err_code != 2'b00);
   // R10: an error leaves the stored word alone and excludes valid
   p_err_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($stable(data) && $stable(is_data) && !valid));
   // R11: after the last sample the receiver waits for an idle line
   p_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid || err) |-> st_q == S_QUIET);
endmodule

// File: rtl/mil_word_codec.sv
module mil_word_codec
   import mwc_pkg::*;
#(
   parameter int unsigned CLK_MHZ     = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tx_start,
   input  logic [15:0] tx_data,
   input  logic        tx_is_data,
   output logic        tx_busy,
   output logic        tx_pos,
   output logic        tx_neg,
   output logic        tx_inhibit,
   input  logic        rx_pos,
   input  logic        rx_neg,
   input  logic        rx_chk_type,
   input  logic        rx_exp_data,
   output logic        rx_valid,
   output logic [15:0] rx_data,
   output logic        rx_is_data,
   output logic        rx_err,
   output logic [1:0]  rx_err_code
);
   localparam int unsigned HALF = half_cycles(CLK_MHZ);

   initial begin
      a_clk_rate_r12: assert (CLK_MHZ == 12 || CLK_MHZ == 16 || CLK_MHZ == 20 || CLK_MHZ == 24)
         else $error("unsupported CLK_MHZ %0d", CLK_MHZ);
      a_sync_depth: assert (SYNC_STAGES <= 4)
         else $error("SYNC_STAGES %0d too deep", SYNC_STAGES);
   end

   logic [1:0] rx_line;

   mwc_tx #(.HALF(HALF)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(tx_start), .data(tx_data),
      .is_data(tx_is_data), .busy(tx_busy), .line_pos(tx_pos),
      .line_neg(tx_neg), .inhibit(tx_inhibit)
   );

   mwc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({rx_pos, rx_neg}), .dout(rx_line)
   );

   mwc_rx #(.HALF(HALF)) u_rx (
      .clk(clk), .rst_n(rst_n), .lpos(rx_line[1]), .lneg(rx_line[0]),
      .chk_type(rx_chk_type), .exp_data(rx_exp_data), .valid(rx_valid),
      .data(rx_data), .is_data(rx_is_data), .err(rx_err), .err_code(rx_err_code)
   );
endmodule

// File: tb/sim_mil_word_codec.sv
module sim_mil_word_codec;
   localparam int H0 = 6;
   localparam int H1 = 10;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n;
   logic tx_start, tx_is_data, b_pos, b_neg, chk_type, exp_data;
   logic [15:0] tx_data;
   logic tx_busy, tx_pos, tx_neg, tx_inhibit, rx_valid, rx_is_data, rx_err;
   logic [15:0] rx_data;
   logic [1:0] rx_err_code;

   logic l_start, l_isd, l_busy, l_pos, l_neg, l_inh, l_valid, l_risd, l_err;
   logic [15:0] l_data, l_rdata;
   logic [1:0] l_code;

   int checks = 0;
   int errors = 0;

   mil_word_codec u0 (
      .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_data(tx_data),
      .tx_is_data(tx_is_data), .tx_busy(tx_busy), .tx_pos(tx_pos), .tx_neg(tx_neg),
      .tx_inhibit(tx_inhibit), .rx_pos(b_pos), .rx_neg(b_neg), .rx_chk_type(chk_type),
      .rx_exp_data(exp_data), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_is_data(rx_is_data), .rx_err(rx_err), .rx_err_code(rx_err_code)
   );

   mil_word_codec #(.CLK_MHZ(20), .SYNC_STAGES(2)) u1 (
      .clk(clk), .rst_n(rst_n), .tx_start(l_start), .tx_data(l_data),
      .tx_is_data(l_isd), .tx_busy(l_busy), .tx_pos(l_pos), .tx_neg(l_neg),
      .tx_inhibit(l_inh), .rx_pos(l_pos), .rx_neg(l_neg), .rx_chk_type(1'b0),
      .rx_exp_data(1'b0), .rx_valid(l_valid), .rx_data(l_rdata),
      .rx_is_data(l_risd), .rx_err(l_err), .rx_err_code(l_code)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Bench model of a word: first-sent half-bit in bit 39.
   function automatic logic [39:0] ref_word(input logic [15:0] d, input logic isd);
      logic [39:0] h;
      int pos;
      int ones;
      logic hi;
      hi = ~isd;
      h = '0;
      pos = 39;
      for (int k = 0; k < 6; k++) begin
         h[pos] = (k < 3) ? hi : ~hi;
         pos--;
      end
      ones = 0;
      for (int b = 15; b >= 0; b--) begin
         h[pos] = d[b];
         h[pos-1] = ~d[b];
         pos -= 2;
         if (d[b]) ones++;
      end
      h[1] = (ones % 2 == 0);
      h[0] = ~h[1];
      return h;
   endfunction

   task automatic t_reset;
      check(tx_inhibit === 1'b1 && tx_pos === 1'b0 && tx_neg === 1'b0, "R4", "idle tx lines",
            {tx_inhibit, tx_pos, tx_neg}, 3'b100);
      check(tx_busy === 1'b0 && rx_valid === 1'b0 && rx_err === 1'b0, "R4", "reset strobes",
            {tx_busy, rx_valid, rx_err}, 0);
   endtask

   // R1 R2 R3 R4 R5: every cycle of the word is compared to the model
   task automatic t_tx_word(input logic [15:0] d, input logic isd, input bit disturb,
                            input string req);
      logic [39:0] h;
      logic lvl;
      int bad;
      int spurious;
      h = ref_word(d, isd);
      bad = 0;
      @(negedge clk);
      tx_start = 1'b1; tx_data = d; tx_is_data = isd;
      @(negedge clk);
      tx_start = 1'b0;
      for (int n = 0; n < 40*H0; n++) begin
         lvl = h[39 - n/H0];
         if (tx_pos !== lvl || tx_neg !== ~lvl || tx_inhibit !== 1'b0 || tx_busy !== 1'b1) bad++;
         if (disturb && n == 50) begin
            tx_start = 1'b1; tx_data = ~d; tx_is_data = ~isd;
         end
         if (disturb && n == 51) tx_start = 1'b0;
         @(negedge clk);
      end
      check(bad == 0, req, "waveform mismatched cycles", bad, 0);
      check(tx_busy === 1'b0 && tx_inhibit === 1'b1 && tx_pos === 1'b0 && tx_neg === 1'b0,
            "R4", "idle after 40 half-bits", {tx_busy, tx_inhibit, tx_pos, tx_neg}, 4'b0100);
      spurious = 0;
      for (int n = 0; n < 3*H0; n++) begin
         if (tx_busy !== 1'b0) spurious++;
         @(negedge clk);
      end
      check(spurious == 0, disturb ? "R5" : "R4", "no word after the end", spurious, 0);
   endtask

   // Drive a half-bit pattern into the receiver and watch for strobes.
   task automatic t_rx(input logic [39:0] h, input logic chk, input logic expd,
                       input bit want_valid, input logic [1:0] want_code,
                       input logic [15:0] want_data, input logic want_isd, input string req);
      int pulses;
      logic got_valid;
      logic [1:0] got_code;
      logic [15:0] got_data;
      logic got_isd;
      pulses = 0;
      got_valid = 1'b0;
      got_code = 2'b00;
      got_data = 16'h0;
      got_isd = 1'b0;
      chk_type = chk;
      exp_data = expd;
      @(negedge clk);
      fork
         begin
            for (int k = 39; k >= 0; k--) begin
               b_pos = h[k];
               b_neg = ~h[k];
               repeat (H0) @(negedge clk);
            end
            b_pos = 1'b0;
            b_neg = 1'b0;
         end
         begin
            for (int n = 0; n < 46*H0; n++) begin
               @(negedge clk);
               if (rx_valid === 1'b1 || rx_err === 1'b1) begin
                  pulses++;
                  got_valid = rx_valid;
                  got_code = rx_err_code;
               end
            end
            got_data = rx_data;
            got_isd = rx_is_data;
         end
      join
      check(pulses == 1, "R11", "strobes per word", pulses, 1);
      check(got_valid == want_valid, req, "valid vs error", got_valid, want_valid);
      if (!want_valid) check(got_code == want_code, req, "error code", got_code, want_code);
      check(got_data == want_data, want_valid ? req : "R10", "rx_data", got_data, want_data);
      check(got_isd == want_isd, want_valid ? req : "R10", "rx_is_data", got_isd, want_isd);
   endtask

   // R12: loopback at 20 MHz
   task automatic t_loop(input logic [15:0] d, input logic isd);
      int busy_cycles;
      int got;
      logic [15:0] gd;
      logic gi;
      busy_cycles = 0;
      got = 0;
      gd = 16'h0;
      gi = 1'b0;
      @(negedge clk);
      l_start = 1'b1; l_data = d; l_isd = isd;
      @(negedge clk);
      l_start = 1'b0;
      for (int n = 0; n < 46*H1; n++) begin
         if (l_busy === 1'b1) busy_cycles++;
         if (l_valid === 1'b1) begin
            got++;
            gd = l_rdata;
            gi = l_risd;
         end
         if (l_err === 1'b1) got += 100;
         @(negedge clk);
      end
      check(busy_cycles == 40*H1, "R12", "word length at 20 MHz", busy_cycles, 40*H1);
      check(got == 1 && gd == d && gi == isd, "R12", "loopback word", {got[7:0], gd, 7'd0, gi},
            {8'd1, d, 7'd0, isd});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [39:0] w;
      rst_n = 1'b0;
      tx_start = 1'b0; tx_data = 16'h0; tx_is_data = 1'b0;
      b_pos = 1'b0; b_neg = 1'b0; chk_type = 1'b0; exp_data = 1'b0;
      l_start = 1'b0; l_data = 16'h0; l_isd = 1'b0;
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      t_tx_word(16'hA5C3, 1'b0, 1'b0, "R1");
      t_tx_word(16'h0000, 1'b1, 1'b0, "R3");
      t_tx_word(16'h8001, 1'b1, 1'b1, "R5");

      t_rx(ref_word(16'h1234, 1'b0), 1'b0, 1'b0, 1'b1, 2'b00, 16'h1234, 1'b0, "R6");
      t_rx(ref_word(16'hFFFF, 1'b1), 1'b1, 1'b1, 1'b1, 2'b00, 16'hFFFF, 1'b1, "R6");

      w = ref_word(16'h0F0F, 1'b0);
      w[1:0] = ~w[1:0];
      t_rx(w, 1'b0, 1'b0, 1'b0, 2'b10, 16'hFFFF, 1'b1, "R8");

      w = ref_word(16'h8001, 1'b0);
      w[2] = w[3];
      t_rx(w, 1'b0, 1'b0, 1'b0, 2'b01, 16'hFFFF, 1'b1, "R7");

      t_rx(ref_word(16'h5555, 1'b0), 1'b1, 1'b1, 1'b0, 2'b11, 16'hFFFF, 1'b1, "R9");

      w = ref_word(16'h3C3C, 1'b1);
      w[37] = ~w[37];
      t_rx(w, 1'b0, 1'b0, 1'b0, 2'b11, 16'hFFFF, 1'b1, "R9");

      w = ref_word(16'h3C3C, 1'b1);
      w[36] = ~w[36];
      w[10] = w[11];
      w[1:0] = ~w[1:0];
      t_rx(w, 1'b0, 1'b0, 1'b0, 2'b11, 16'hFFFF, 1'b1, "R9");

      w = ref_word(16'h7E01, 1'b1);
      w[20] = w[21];
      w[1:0] = ~w[1:0];
      t_rx(w, 1'b0, 1'b0, 1'b0, 2'b01, 16'hFFFF, 1'b1, "R7");

      t_rx(ref_word(16'h0001, 1'b1), 1'b0, 1'b0, 1'b1, 2'b00, 16'h0001, 1'b1, "R2");

      t_loop(16'hC0DE, 1'b1);
      t_loop(16'h4321, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule